// File: doc/BRIEF.md
# NAND Prefetch and Write-Posting FIFO Engine

This block moves a programmed number of bytes between a host bus and a byte-wide NAND data port through one shared 64-byte FIFO. A single start pulse carries the byte count, the direction and a flag that selects DMA pacing. In the read direction the engine pulls bytes from the NAND port whenever the device signals ready and the FIFO has room. The host then takes them out as 32-bit words. In the write direction the host posts 16-bit halfwords into the FIFO, and the engine writes them out byte by byte to the NAND port.

Software watches a packed status word. One field gives the FIFO level and another gives how many bytes are still to cross the NAND port. When DMA pacing is selected, a request line tells a DMA engine that a full 64-byte frame can be moved. The engine stays busy until an explicit abort. Any start that arrives while it is busy is refused. NAND timing is reduced to a ready input and one strobe per byte.

Top module: `nand_pfq_engine`

## Requirements
- R1: After reset `status` is zero, `busy`, `dma_req`, `nand_re` and `nand_we` are low.
- R2: A `start` pulse while idle is taken at the clock edge. From the next cycle `busy` is high and `status[13:0]` equals the programmed byte count. `start_dir` 0 selects read and 1 selects write.
- R3: A `start` while busy raises `start_nack` in the same cycle. It changes neither the direction nor the remaining count.
- R4: In read mode every `nand_re` cycle latches `nand_din` into the FIFO. Host words carry the bytes in NAND order, with the earliest byte in bits 7:0. Read lengths are multiples of 4.
- R5: In read mode `status[30:24]` is the number of bytes held. `status[13:0]` is the number of bytes not yet fetched. No byte is fetched while 64 bytes are held.
- R6: A host read stalls (`hrd_wait` high) while fewer than 4 bytes are held or when all words of the transfer have been taken.
- R7: In write mode each halfword is sent low byte first, in posting order. `status[30:24]` is the number of free bytes, and `status[13:0]` is the number of bytes not yet written to the NAND port.
- R8: A host write stalls (`hwr_wait` high) while fewer than 2 bytes are free or when all halfwords of the transfer have been posted.
- R9: `dma_req` is high only when busy in DMA mode. In read mode it needs at least 64 bytes held. In write mode it needs at least 64 bytes free and halfwords still to post.
- R10: `abort` clears `busy`, the remaining count and the FIFO. A following start is accepted.
- R11: A NAND strobe occurs only when busy, with `nand_rdy` high and a non-zero remaining count. A transfer produces exactly its byte count of strobes.
- R12: Status bits 31 and 23:14 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| start_dir | input | 1 | 0 read from NAND, 1 write to NAND |
| start_dma | input | 1 | Enable DMA frame requests |
| start_len | input | 14 | Transfer length in bytes |
| abort | input | 1 | Stop engine and clear FIFO |
| start_nack | output | 1 | Start refused because busy |
| busy | output | 1 | Engine enabled |
| status | output | 32 | Level in 30:24, remaining count in 13:0 |
| dma_req | output | 1 | Frame ready for DMA |
| hrd_req | input | 1 | Host word read request |
| hrd_wait | output | 1 | Host read stall |
| hrd_data | output | 32 | Host read word |
| hwr_req | input | 1 | Host halfword write request |
| hwr_wait | output | 1 | Host write stall |
| hwr_data | input | 16 | Host write halfword |
| nand_rdy | input | 1 | NAND port ready |
| nand_re | output | 1 | NAND read strobe |
| nand_we | output | 1 | NAND write strobe |
| nand_din | input | 8 | NAND read byte |
| nand_dout | output | 8 | NAND write byte |

## Verification
Reads are tried with lengths below, at and well above one frame. Each length runs with a NAND port that is always ready and with one that is ready on a pseudo-random half of the cycles, and with and without DMA pacing. This separates byte-order faults from pacing faults and shows the fill stop at 64 bytes. Writes are first posted with the NAND port stalled, which exposes the free-space field, the full stall and the write-side DMA level. The port is then released so the byte stream can be compared. Refused starts and aborts sit inside every run, so stale state would show up in the next transfer.

// File: rtl/nand_pfq_pkg.sv
package nand_pfq_pkg;

   localparam int unsigned OCC_FIELD_W   = 7;
   localparam int unsigned OCC_FIELD_LSB = 24;
   localparam int unsigned CNT_FIELD_W   = 14;
   localparam int unsigned HOST_RD_BYTES = 4;
   localparam int unsigned HOST_WR_BYTES = 2;

   typedef enum logic {
      XFER_RD = 1'b0,
      XFER_WR = 1'b1
   } xfer_dir_e;

   function automatic logic [31:0] pack_status(input logic [OCC_FIELD_W-1:0] lvl,
                                               input logic [CNT_FIELD_W-1:0] cnt);
      logic [31:0] s;
      s = '0;
      s[OCC_FIELD_LSB +: OCC_FIELD_W] = lvl;
      s[CNT_FIELD_W-1:0] = cnt;
      return s;
   endfunction

endpackage

// File: rtl/nand_pfq_fifo.sv
module nand_pfq_fifo #(
   parameter  int unsigned DEPTH  = 64,
   parameter  int unsigned WR_MAX = 2,
   parameter  int unsigned RD_MAX = 4,
   localparam int unsigned AW     = $clog2(DEPTH),
   localparam int unsigned CW     = AW + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  wr_en,
   input  logic [CW-1:0]         wr_n,
   input  logic [8*WR_MAX-1:0]   wr_data,
   input  logic                  rd_en,
   input  logic [CW-1:0]         rd_n,
   output logic [8*RD_MAX-1:0]   rd_data,
   output logic [CW-1:0]         occ
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < RD_MAX) begin : g_bad_depth
      $error("nand_pfq_fifo: DEPTH must be a power of two not below RD_MAX");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] occ_q;

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         for (int i = 0; i < int'(WR_MAX); i++) begin
            if (CW'(i) < wr_n) mem[wptr + AW'(i)] <= wr_data[8*i +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         occ_q <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         occ_q <= '0;
      end else begin
         if (wr_en) wptr <= wptr + wr_n[AW-1:0];
         if (rd_en) rptr <= rptr + rd_n[AW-1:0];
         occ_q <= occ_q + (wr_en ? wr_n : '0) - (rd_en ? rd_n : '0);
      end
   end

   for (genvar g = 0; g < int'(RD_MAX); g++) begin : g_lane
      assign rd_data[8*g +: 8] = mem[rptr + AW'(g)];
   end

   assign occ = occ_q;

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |-> (int'(occ_q) + int'(wr_n) <= int'(DEPTH)));

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !flush) |-> (occ_q >= rd_n));

endmodule

// File: rtl/nand_pfq_ctrl.sv
module nand_pfq_ctrl
   import nand_pfq_pkg::*;
#(
   parameter  int unsigned DEPTH = 64,
   parameter  int unsigned FRAME = 64,
   parameter  int unsigned LEN_W = 14,
   localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_dir,
   input  logic             start_dma,
   input  logic [LEN_W-1:0] start_len,
   input  logic             abort,
   input  logic             hrd_req,
   input  logic             hwr_req,
   input  logic             nand_rdy,
   input  logic [CW-1:0]    occ,
   output logic             busy,
   output logic             dir_wr,
   output logic [LEN_W-1:0] nand_left,
   output logic             start_nack,
   output logic             flush,
   output logic             fifo_wr_en,
   output logic [CW-1:0]    fifo_wr_n,
   output logic             fifo_rd_en,
   output logic [CW-1:0]    fifo_rd_n,
   output logic             hrd_wait,
   output logic             hwr_wait,
   output logic             nand_re,
   output logic             nand_we,
   output logic             dma_req
);

   localparam logic [CW-1:0]    DEPTH_C = CW'(DEPTH);
   localparam logic [CW-1:0]    FRAME_C = CW'(FRAME);
   localparam logic [CW-1:0]    RD_C    = CW'(HOST_RD_BYTES);
   localparam logic [CW-1:0]    WR_C    = CW'(HOST_WR_BYTES);
   localparam logic [LEN_W-1:0] RD_L    = LEN_W'(HOST_RD_BYTES);
   localparam logic [LEN_W-1:0] WR_L    = LEN_W'(HOST_WR_BYTES);

   logic             busy_q, dma_q;
   xfer_dir_e        dir_q;
   logic [LEN_W-1:0] nand_left_q, host_left_q, step, host_left_nx;
   logic             start_ok, rd_go, wr_go, host_pop, host_push;

   assign start_ok = start && !busy_q && !abort;
   assign rd_go    = busy_q && (dir_q == XFER_RD);
   assign wr_go    = busy_q && (dir_q == XFER_WR);

   assign nand_re   = rd_go && nand_rdy && (nand_left_q != '0) && (occ < DEPTH_C);
   assign host_pop  = rd_go && hrd_req && (host_left_q != '0) && (occ >= RD_C);
   assign host_push = wr_go && hwr_req && (host_left_q != '0) && (occ <= DEPTH_C - WR_C);
   assign nand_we   = wr_go && nand_rdy && (nand_left_q != '0) && (occ != '0);

   assign step         = (dir_q == XFER_WR) ? WR_L : RD_L;
   assign host_left_nx = (host_left_q > step) ? host_left_q - step : '0;

   assign fifo_wr_en = nand_re || host_push;
   assign fifo_wr_n  = (dir_q == XFER_WR) ? WR_C : CW'(1);
   assign fifo_rd_en = host_pop || nand_we;
   assign fifo_rd_n  = (dir_q == XFER_WR) ? CW'(1) : RD_C;
   assign flush      = abort || start_ok;

   assign hrd_wait   = hrd_req && !host_pop;
   assign hwr_wait   = hwr_req && !host_push;
   assign start_nack = start && busy_q;

   assign dma_req = busy_q && dma_q &&
                    ((dir_q == XFER_WR) ? ((DEPTH_C - occ) >= FRAME_C && host_left_q != '0)
                                        : (occ >= FRAME_C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         dma_q       <= 1'b0;
         dir_q       <= XFER_RD;
         nand_left_q <= '0;
         host_left_q <= '0;
      end else if (abort) begin
         busy_q      <= 1'b0;
         nand_left_q <= '0;
         host_left_q <= '0;
      end else if (start_ok) begin
         busy_q      <= 1'b1;
         dma_q       <= start_dma;
         dir_q       <= xfer_dir_e'(start_dir);
         nand_left_q <= start_len;
         host_left_q <= start_len;
      end else begin
         if (nand_re || nand_we)   nand_left_q <= nand_left_q - 1'b1;
         if (host_pop || host_push) host_left_q <= host_left_nx;
      end
   end

   assign busy      = busy_q;
   assign dir_wr    = (dir_q == XFER_WR);
   assign nand_left = nand_left_q;

   assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy_q && nand_left_q == '0 && occ == '0));

   assert_refuse_keeps_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy_q && !abort) |=> (busy_q && dir_q == $past(dir_q) && nand_left_q <= $past(nand_left_q)));

   assert_count_never_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start_ok) |=> (nand_left_q <= $past(nand_left_q)));

endmodule

// File: rtl/nand_pfq_engine.sv
module nand_pfq_engine
   import nand_pfq_pkg::*;
#(
   parameter int unsigned FIFO_BYTES  = 64,
   parameter int unsigned FRAME_BYTES = 64,
   parameter int unsigned LEN_W       = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_dir,
   input  logic             start_dma,
   input  logic [LEN_W-1:0] start_len,
   input  logic             abort,
   output logic             start_nack,
   output logic             busy,
   output logic [31:0]      status,
   output logic             dma_req,
   input  logic             hrd_req,
   output logic             hrd_wait,
   output logic [31:0]      hrd_data,
   input  logic             hwr_req,
   output logic             hwr_wait,
   input  logic [15:0]      hwr_data,
   input  logic             nand_rdy,
   output logic             nand_re,
   output logic             nand_we,
   input  logic [7:0]       nand_din,
   output logic [7:0]       nand_dout
);

   localparam int unsigned CW = $clog2(FIFO_BYTES) + 1;

   if (LEN_W > CNT_FIELD_W || CW > OCC_FIELD_W || FRAME_BYTES > FIFO_BYTES
       || FRAME_BYTES == 0) begin : g_bad_cfg
      $error("nand_pfq_engine: configuration does not fit the status layout");
   end

   logic             flush, dir_wr;
   logic             fifo_wr_en, fifo_rd_en;
   logic [CW-1:0]    fifo_wr_n, fifo_rd_n, occ;
   logic [15:0]      fifo_wr_data;
   logic [31:0]      fifo_rd_data;
   logic [LEN_W-1:0] nand_left;
   logic [CW-1:0]    lvl;

   nand_pfq_ctrl #(.DEPTH(FIFO_BYTES), .FRAME(FRAME_BYTES), .LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
      .start_dma(start_dma), .start_len(start_len), .abort(abort),
      .hrd_req(hrd_req), .hwr_req(hwr_req), .nand_rdy(nand_rdy), .occ(occ),
      .busy(busy), .dir_wr(dir_wr), .nand_left(nand_left), .start_nack(start_nack),
      .flush(flush), .fifo_wr_en(fifo_wr_en), .fifo_wr_n(fifo_wr_n),
      .fifo_rd_en(fifo_rd_en), .fifo_rd_n(fifo_rd_n), .hrd_wait(hrd_wait),
      .hwr_wait(hwr_wait), .nand_re(nand_re), .nand_we(nand_we), .dma_req(dma_req)
   );

   assign fifo_wr_data = dir_wr ? hwr_data : {8'h00, nand_din};

   nand_pfq_fifo #(.DEPTH(FIFO_BYTES), .WR_MAX(HOST_WR_BYTES), .RD_MAX(HOST_RD_BYTES)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(fifo_wr_en), .wr_n(fifo_wr_n), .wr_data(fifo_wr_data),
      .rd_en(fifo_rd_en), .rd_n(fifo_rd_n), .rd_data(fifo_rd_data), .occ(occ)
   );

   assign lvl       = dir_wr ? (CW'(FIFO_BYTES) - occ) : occ;
   assign status    = pack_status(OCC_FIELD_W'(lvl), CNT_FIELD_W'(nand_left));
   assign hrd_data  = fifo_rd_data;
   assign nand_dout = fifo_rd_data[7:0];

   assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_re && nand_we));

   assert_dma_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> busy);

endmodule

// File: tb/tb_nand_pfq_engine.sv
module tb_nand_pfq_engine;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, start_dir = 1'b0, start_dma = 1'b0, abort = 1'b0;
   logic [13:0] start_len = '0;
   logic        start_nack, busy, dma_req;
   logic [31:0] status;
   logic        hrd_req = 1'b0, hrd_wait;
   logic [31:0] hrd_data;
   logic        hwr_req = 1'b0, hwr_wait;
   logic [15:0] hwr_data = '0;
   logic        nand_rdy = 1'b0, nand_re, nand_we;
   logic [7:0]  nand_din, nand_dout;

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   int   rdy_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   int   rseed = 0;
   int   nidx, wcnt;
   logic clr_log = 1'b0;
   logic [7:0] wlog [0:1023];

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_pfq_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
      .start_dma(start_dma), .start_len(start_len), .abort(abort),
      .start_nack(start_nack), .busy(busy), .status(status), .dma_req(dma_req),
      .hrd_req(hrd_req), .hrd_wait(hrd_wait), .hrd_data(hrd_data),
      .hwr_req(hwr_req), .hwr_wait(hwr_wait), .hwr_data(hwr_data),
      .nand_rdy(nand_rdy), .nand_re(nand_re), .nand_we(nand_we),
      .nand_din(nand_din), .nand_dout(nand_dout)
   );

   function automatic logic [7:0] rbyte(int seed, int k);
      return 8'(seed * 37 + k * 13 + (k >> 3));
   endfunction

   function automatic logic [15:0] whalf(int seed, int k);
      return 16'(seed * 91 + k * 257 + 3);
   endfunction

   function automatic logic [31:0] st(int lvl, int cnt);
      return {1'b0, 7'(lvl), 10'b0, 14'(cnt)};
   endfunction

   assign nand_din = rbyte(rseed, nidx);

   always @(posedge clk) begin
      if (clr_log) begin
         nidx <= 0;
         wcnt <= 0;
      end else begin
         if (nand_re) nidx <= nidx + 1;
         if (nand_we) begin
            wlog[wcnt] <= nand_dout;
            wcnt <= wcnt + 1;
         end
      end
   end

   always @(negedge clk) begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      nand_rdy <= (rdy_mode == 1) || (rdy_mode == 2 && lfsr[0]);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      @(negedge clk) clr_log = 1'b1;
      @(negedge clk) clr_log = 1'b0;
   endtask

   task automatic do_start(input bit dir, input bit dma, input int len);
      @(negedge clk);
      start = 1'b1; start_dir = dir; start_dma = dma; start_len = 14'(len);
      @(negedge clk);
      start = 1'b0;
      #1;
   endtask

   task automatic do_abort();
      @(negedge clk) abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      #1;
   endtask

   task automatic host_read(output logic [31:0] d);
      hrd_req = 1'b1;
      #1;
      while (hrd_wait) begin
         @(negedge clk);
         #1;
      end
      d = hrd_data;
      @(posedge clk);
      @(negedge clk) hrd_req = 1'b0;
   endtask

   task automatic host_write(input logic [15:0] h);
      hwr_req = 1'b1;
      hwr_data = h;
      #1;
      while (hwr_wait) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk) hwr_req = 1'b0;
   endtask

   task automatic wait_count_zero(input string req);
      int t;
      t = 0;
      while (status[13:0] != 0 && t < 2000) begin
         @(negedge clk);
         #1;
         t++;
      end
      chk(t < 2000, req, "remaining count reaches zero", status, st(0, 0));
   endtask

   task automatic run_read(input int len, input int mode, input bit dma);
      int held, bad;
      logic [31:0] d, e, first_act, first_exp;
      clear_log();
      rseed = len + mode * 3 + int'(dma);
      rdy_mode = 0;
      do_start(1'b0, dma, len);
      chk(busy && status == st(0, len), "R2", "read start load", status, st(0, len));
      hrd_req = 1'b1;
      #1;
      chk(hrd_wait == 1'b1, "R6", "read stalls on empty FIFO", 32'(hrd_wait), 32'd1);
      chk(dma_req == 1'b0, "R9", "no read DMA when empty", 32'(dma_req), 32'd0);
      hrd_req = 1'b0;
      start = 1'b1; start_len = 14'(len ^ 5); start_dir = 1'b1;
      #1;
      chk(start_nack == 1'b1, "R3", "start refused while busy", 32'(start_nack), 32'd1);
      @(negedge clk) start = 1'b0;
      #1;
      chk(status == st(0, len), "R3", "refused start keeps count", status, st(0, len));
      rdy_mode = mode;
      repeat (400) @(negedge clk);
      #1;
      held = (len < 64) ? len : 64;
      chk(status == st(held, len - held), "R5", "fill level and count", status, st(held, len - held));
      chk(nand_re == 1'b0, "R5", "no fetch beyond fill", 32'(nand_re), 32'd0);
      chk(dma_req == (dma && len >= 64), "R9", "read DMA level", 32'(dma_req), 32'(dma && len >= 64));
      bad = 0;
      first_act = '0; first_exp = '0;
      for (int w = 0; w < len / 4; w++) begin
         host_read(d);
         e = {rbyte(rseed, 4*w+3), rbyte(rseed, 4*w+2), rbyte(rseed, 4*w+1), rbyte(rseed, 4*w)};
         if (d !== e && bad == 0) begin
            first_act = d;
            first_exp = e;
         end
         if (d !== e) bad++;
      end
      chk(bad == 0, "R4", "read word order", first_act, first_exp);
      wait_count_zero("R5");
      chk(status == st(0, 0), "R12", "read status after drain", status, st(0, 0));
      chk(nidx == len, "R11", "read strobe total", 32'(nidx), 32'(len));
      hrd_req = 1'b1;
      #1;
      chk(hrd_wait == 1'b1, "R6", "read stalls after last word", 32'(hrd_wait), 32'd1);
      hrd_req = 1'b0;
      do_abort();
      chk(!busy && status == st(0, 0), "R10", "abort after read", status, st(0, 0));
   endtask

   task automatic run_write(input int len, input int mode, input bit dma);
      int pre, bad;
      logic [15:0] h;
      logic [31:0] first_act, first_exp;
      clear_log();
      rseed = len + mode * 5 + int'(dma);
      rdy_mode = 0;
      do_start(1'b1, dma, len);
      chk(busy && status == st(64, len), "R7", "write start free level", status, st(64, len));
      chk(dma_req == dma, "R9", "write DMA when empty", 32'(dma_req), 32'(dma));
      pre = (len / 2 < 32) ? len / 2 : 32;
      for (int k = 0; k < pre; k++) host_write(whalf(rseed, k));
      #1;
      chk(status == st(64 - 2*pre, len), "R7", "free level after posting", status, st(64 - 2*pre, len));
      chk(nand_we == 1'b0, "R11", "no write strobe while not ready", 32'(nand_we), 32'd0);
      if (len >= 64) begin
         hwr_req = 1'b1;
         #1;
         chk(hwr_wait == 1'b1, "R8", "write stalls on full FIFO", 32'(hwr_wait), 32'd1);
         chk(dma_req == 1'b0, "R9", "no write DMA when full", 32'(dma_req), 32'd0);
         hwr_req = 1'b0;
      end
      rdy_mode = mode;
      for (int k = pre; k < len / 2; k++) host_write(whalf(rseed, k));
      wait_count_zero("R7");
      bad = 0;
      first_act = '0; first_exp = '0;
      for (int k = 0; k < len / 2; k++) begin
         h = whalf(rseed, k);
         if ({wlog[2*k+1], wlog[2*k]} !== h) begin
            if (bad == 0) begin
               first_act = {16'h0, wlog[2*k+1], wlog[2*k]};
               first_exp = {16'h0, h};
            end
            bad++;
         end
      end
      chk(bad == 0, "R7", "write byte order", first_act, first_exp);
      chk(wcnt == len, "R11", "write strobe total", 32'(wcnt), 32'(len));
      chk(status == st(64, 0), "R12", "write status after flush", status, st(64, 0));
      chk(dma_req == 1'b0, "R9", "no write DMA after last post", 32'(dma_req), 32'd0);
      hwr_req = 1'b1;
      #1;
      chk(hwr_wait == 1'b1, "R8", "write stalls after last halfword", 32'(hwr_wait), 32'd1);
      hwr_req = 1'b0;
      do_abort();
      chk(!busy && status == st(64, 0), "R10", "abort after write", status, st(64, 0));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int rl[6];
      int wl[4];
      rl = '{4, 8, 60, 64, 128, 200};
      wl = '{2, 6, 64, 130};
      clr_log = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clr_log = 1'b0;
      #1;
      chk(status == 32'h0, "R1", "reset status", status, 32'h0);
      chk(!busy && !dma_req && !nand_re && !nand_we, "R1", "reset controls",
          {28'h0, busy, dma_req, nand_re, nand_we}, 32'h0);
      for (int d = 0; d < 2; d++)
         for (int m = 1; m <= 2; m++)
            for (int i = 0; i < 6; i++) run_read(rl[i], m, d[0]);
      for (int d = 0; d < 2; d++)
         for (int m = 1; m <= 2; m++)
            for (int i = 0; i < 4; i++) run_write(wl[i], m, d[0]);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule